// File: doc/BRIEF.md
# Byte-Wide Data Memory with Pointer Indirection

This block is the data store of a small 8-bit controller. It decodes a 256-byte address space into four kinds of location: a bank of special function register slots at the bottom, a reserved hole that holds nothing, general-purpose RAM from 60H up to FFH, and two virtual ports. The virtual ports have no storage of their own. An access to one of them is steered to the address held in that port's pointer register. The first port sits at 00H and uses the pointer at 01H. The second port sits at 02H and uses the pointer at 03H.

The block has one combinational read port and one write port, which commits on the rising clock edge. Both ports can be used in the same cycle. Each port runs its own copy of the address decoder. The decoder sorts every access into one of the regions virtual, special register, reserved, general RAM, or blocked. A redirected access whose pointer names one of the virtual ports is blocked. A blocked read returns zero and a blocked write is dropped, so an access can never be redirected twice. Both pointer values are brought out as ports for the address logic next to the block. The accumulator slot sits at 05H and the status slot at 0AH. These two slots and every other unmodelled special register slot behave as plain read/write bytes.

Top module: `sfr_data_memory`

## Requirements
- R1: An active-low asynchronous reset clears the pointers at 01H and 03H, the accumulator at 05H and the status slot at 0AH, so that each of them reads 00H after reset.
- R2: A write to any address from 60H to FFH stores the byte, and a later read of that address returns it.
- R3: The addresses 1AH to 1DH and 20H to 5FH are reserved. They always read 00H, also when reached through a pointer, and writes to them do not change what they read.
- R4: A read of 00H returns the byte at the address held in the pointer at 01H, and a write to 00H stores at that address. The pointed-to address may be any special register slot, RAM byte or reserved address.
- R5: A read or write at 02H is redirected in the same way through the pointer at 03H.
- R6: When the pointer selected by a virtual port holds 00H or 02H, a read of that port returns 00H.
- R7: When the pointer selected by a virtual port holds 00H or 02H, a write to that port changes no storage, and both pointer outputs stay as they were.
- R8: A pointer loaded by a write at 01H or 03H appears on its output port after that clock edge, and the very next access uses the new value.
- R9: The special register slots 01H, 03H to 19H, 1EH and 1FH are read/write bytes. This includes the accumulator at 05H and the status slot at 0AH.
- R10: Reads are combinational. A read of the address that is being written in the same cycle returns the old byte, and the new byte is returned from the following cycle on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; writes commit on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| rd_addr | input | 8 | Read address |
| rd_data | output | 8 | Combinational read data |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 8 | Write address |
| wr_data | input | 8 | Write data |
| ptr0_q | output | 8 | Pointer used by virtual port 00H |
| ptr1_q | output | 8 | Pointer used by virtual port 02H |

## Verification
The hardest case to reach is the dropped write through a self-referencing pointer. It needs a pointer loaded with 00H or 02H first, and its only visible trace is that nothing changes. The stimulus loads each pointer with a virtual address and writes through the port. It then reads back both pointer outputs and the bytes the write could have reached, and these must be unchanged. The same-cycle read-during-write is driven on a single cycle with both ports aimed at one RAM byte. The redirected write to reserved space is likewise followed by a direct read of its target.

// File: rtl/dmem_pkg.sv
package dmem_pkg;

    // Classification of one access after pointer redirection.
    typedef enum logic [2:0] {
        RG_VIRTUAL,
        RG_SFR,
        RG_RESERVED,
        RG_GPR,
        RG_BLOCKED
    } region_e;

endpackage

// File: rtl/dmem_decode.sv
module dmem_decode
    import dmem_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int SFR_SLOTS = 32,
    parameter int GPR_BASE  = 96,
    parameter int VPORT0    = 0,
    parameter int VPORT1    = 2,
    parameter logic [SFR_SLOTS-1:0] SFR_MAP = 32'hC3FF_FFFA
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] ptr0,
    input  logic [ADDR_W-1:0] ptr1,
    output logic [ADDR_W-1:0] eff_addr,
    output region_e           region
);
    localparam int IDX_W = $clog2(SFR_SLOTS);
    localparam logic [ADDR_W-1:0] V0_A   = ADDR_W'(VPORT0);
    localparam logic [ADDR_W-1:0] V1_A   = ADDR_W'(VPORT1);
    localparam logic [ADDR_W-1:0] SFR_END = ADDR_W'(SFR_SLOTS);
    localparam logic [ADDR_W-1:0] GPR_A  = ADDR_W'(GPR_BASE);

    function automatic region_e classify(input logic [ADDR_W-1:0] a);
        if (a == V0_A || a == V1_A)
            return RG_VIRTUAL;
        if (a < SFR_END)
            return SFR_MAP[a[IDX_W-1:0]] ? RG_SFR : RG_RESERVED;
        if (a < GPR_A)
            return RG_RESERVED;
        return RG_GPR;
    endfunction

    region_e first_rg;
    region_e second_rg;
    logic [ADDR_W-1:0] redirect;

    always_comb begin
        first_rg  = classify(addr);
        redirect  = (addr == V0_A) ? ptr0 : ptr1;
        second_rg = classify(redirect);
        if (first_rg == RG_VIRTUAL) begin
            eff_addr = redirect;
            region   = (second_rg == RG_VIRTUAL) ? RG_BLOCKED : second_rg;
        end else begin
            eff_addr = addr;
            region   = first_rg;
        end
    end

endmodule

// File: rtl/dmem_sfr.sv
module dmem_sfr #(
    parameter int DATA_W    = 8,
    parameter int SFR_SLOTS = 32,
    parameter logic [SFR_SLOTS-1:0] SFR_MAP = 32'hC3FF_FFFA,
    parameter int PTR0_ADDR = 1,
    parameter int PTR1_ADDR = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [$clog2(SFR_SLOTS)-1:0]  wr_idx,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [$clog2(SFR_SLOTS)-1:0]  rd_idx,
    output logic [DATA_W-1:0]             rd_data,
    output logic [DATA_W-1:0]             ptr0,
    output logic [DATA_W-1:0]             ptr1
);
    localparam int IDX_W = $clog2(SFR_SLOTS);

    logic [DATA_W-1:0] slot_q [SFR_SLOTS];

    for (genvar i = 0; i < SFR_SLOTS; i++) begin : g_slot
        if (SFR_MAP[i]) begin : g_store
            logic [DATA_W-1:0] q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    q <= '0;
                else if (we && wr_idx == IDX_W'(i))
                    q <= wr_data;
            end
            assign slot_q[i] = q;
        end else begin : g_hole
            assign slot_q[i] = '0;
        end
    end

    assign rd_data = slot_q[rd_idx];
    assign ptr0    = slot_q[PTR0_ADDR];
    assign ptr1    = slot_q[PTR1_ADDR];

    // R8: a pointer write is visible on the pointer output after the edge
    p_ptr0_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_idx == IDX_W'(PTR0_ADDR)) |=> ptr0 == $past(wr_data));
    p_ptr1_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (we && wr_idx == IDX_W'(PTR1_ADDR)) |=> ptr1 == $past(wr_data));

endmodule

// File: rtl/dmem_gpr.sv
module dmem_gpr #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 160
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     we,
    input  logic [$clog2(DEPTH)-1:0] wr_idx,
    input  logic [DATA_W-1:0]        wr_data,
    input  logic [$clog2(DEPTH)-1:0] rd_idx,
    output logic [DATA_W-1:0]        rd_data
);
    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[wr_idx] <= wr_data;
    end

    assign rd_data = mem[rd_idx];

    // R2: a stored byte is what the array holds after the edge
    p_gpr_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> mem[$past(wr_idx)] == $past(wr_data));

endmodule

// File: rtl/sfr_data_memory.sv
module sfr_data_memory
    import dmem_pkg::*;
#(
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 8,
    parameter int SFR_SLOTS = 32,
    parameter int GPR_BASE  = 96,
    parameter int VPORT0    = 0,
    parameter int VPORT1    = 2,
    parameter int PTR0_ADDR = 1,
    parameter int PTR1_ADDR = 3,
    parameter logic [SFR_SLOTS-1:0] SFR_MAP = 32'hC3FF_FFFA
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        rd_addr,
    output logic [7:0]        rd_data,
    input  logic              wr_en,
    input  logic [7:0]        wr_addr,
    input  logic [7:0]        wr_data,
    output logic [7:0]        ptr0_q,
    output logic [7:0]        ptr1_q
);
    localparam int SFR_IDX_W = $clog2(SFR_SLOTS);
    localparam int GPR_DEPTH = (1 << ADDR_W) - GPR_BASE;
    localparam int GPR_IDX_W = $clog2(GPR_DEPTH);
    localparam logic [ADDR_W-1:0] GPR_A = ADDR_W'(GPR_BASE);

    logic [ADDR_W-1:0] rd_eff, wr_eff;
    region_e           rd_region, wr_region;
    logic [DATA_W-1:0] sfr_rd, gpr_rd;
    logic              sfr_we, gpr_we;
    logic [ADDR_W-1:0] gpr_rd_off, gpr_wr_off;

    dmem_decode #(
        .ADDR_W(ADDR_W), .SFR_SLOTS(SFR_SLOTS), .GPR_BASE(GPR_BASE),
        .VPORT0(VPORT0), .VPORT1(VPORT1), .SFR_MAP(SFR_MAP)
    ) u_rd_dec (
        .addr(rd_addr), .ptr0(ptr0_q), .ptr1(ptr1_q),
        .eff_addr(rd_eff), .region(rd_region)
    );

    dmem_decode #(
        .ADDR_W(ADDR_W), .SFR_SLOTS(SFR_SLOTS), .GPR_BASE(GPR_BASE),
        .VPORT0(VPORT0), .VPORT1(VPORT1), .SFR_MAP(SFR_MAP)
    ) u_wr_dec (
        .addr(wr_addr), .ptr0(ptr0_q), .ptr1(ptr1_q),
        .eff_addr(wr_eff), .region(wr_region)
    );

    assign sfr_we     = wr_en && (wr_region == RG_SFR);
    assign gpr_we     = wr_en && (wr_region == RG_GPR);
    assign gpr_rd_off = rd_eff - GPR_A;
    assign gpr_wr_off = wr_eff - GPR_A;

    dmem_sfr #(
        .DATA_W(DATA_W), .SFR_SLOTS(SFR_SLOTS), .SFR_MAP(SFR_MAP),
        .PTR0_ADDR(PTR0_ADDR), .PTR1_ADDR(PTR1_ADDR)
    ) u_sfr (
        .clk(clk), .rst_n(rst_n), .we(sfr_we),
        .wr_idx(wr_eff[SFR_IDX_W-1:0]), .wr_data(wr_data),
        .rd_idx(rd_eff[SFR_IDX_W-1:0]), .rd_data(sfr_rd),
        .ptr0(ptr0_q), .ptr1(ptr1_q)
    );

    dmem_gpr #(
        .DATA_W(DATA_W), .DEPTH(GPR_DEPTH)
    ) u_gpr (
        .clk(clk), .rst_n(rst_n), .we(gpr_we),
        .wr_idx(gpr_wr_off[GPR_IDX_W-1:0]), .wr_data(wr_data),
        .rd_idx(gpr_rd_off[GPR_IDX_W-1:0]), .rd_data(gpr_rd)
    );

    always_comb begin
        unique case (rd_region)
            RG_SFR:      rd_data = sfr_rd;
            RG_GPR:      rd_data = gpr_rd;
            RG_RESERVED: rd_data = '0;
            RG_BLOCKED:  rd_data = '0;
            RG_VIRTUAL:  rd_data = '0;
            default:     rd_data = '0;
        endcase
    end

    // R3: reserved space reads as zero
    p_reserved_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_region == RG_RESERVED) |-> rd_data == '0);
    // R6: a doubly redirected read returns zero
    p_blocked_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_region == RG_BLOCKED) |-> rd_data == '0);
    // R7: a blocked write leaves both pointers untouched
    p_blocked_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_region == RG_BLOCKED) |=> ($stable(ptr0_q) && $stable(ptr1_q)));

endmodule

// File: tb/sfr_data_memory_test.sv
module sfr_data_memory_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] rd_addr = '0;
    logic [7:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       wr_en = 1'b0;
    logic       probe = 1'b0;
    logic [7:0] rd_data, ptr0_q, ptr1_q;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] exp_q [$];
    string      tag_q [$];

    always #2.5 clk = ~clk;

    sfr_data_memory uut (
        .clk(clk), .rst_n(rst_n),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ptr0_q(ptr0_q), .ptr1_q(ptr1_q)
    );

    // Monitor: pops one expected item per probed cycle, before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (probe) begin
                logic [7:0] e;
                string      t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                checks++;
                if (rd_data !== e) begin
                    errors++;
                    $display("FAIL %s: rd_addr=%02h actual=%02h expected=%02h", t, rd_addr, rd_data, e);
                end
            end
        end
    end

    task automatic rd(input logic [7:0] a, input logic [7:0] e, input string t);
        @(negedge clk);
        wr_en = 1'b0; rd_addr = a; probe = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        probe = 1'b0; wr_en = 1'b1; wr_addr = a; wr_data = d;
    endtask

    task automatic wr_rd(input logic [7:0] wa, input logic [7:0] d,
                         input logic [7:0] ra, input logic [7:0] e, input string t);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = wa; wr_data = d; rd_addr = ra; probe = 1'b1;
        exp_q.push_back(e); tag_q.push_back(t);
    endtask

    task automatic chk_ptr(input logic [7:0] e0, input logic [7:0] e1, input string t);
        @(negedge clk);
        wr_en = 1'b0; probe = 1'b0;
        #1;
        checks++;
        if (ptr0_q !== e0 || ptr1_q !== e1) begin
            errors++;
            $display("FAIL %s: pointers actual=%02h/%02h expected=%02h/%02h", t, ptr0_q, ptr1_q, e0, e1);
        end
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        chk_ptr(8'h00, 8'h00, "R1");
        rd(8'h01, 8'h00, "R1");
        rd(8'h03, 8'h00, "R1");
        rd(8'h05, 8'h00, "R1");
        rd(8'h0A, 8'h00, "R1");
        rd(8'h00, 8'h00, "R6");

        // R2: general RAM, both ends and the middle
        wr(8'h60, 8'hA5); wr(8'hFF, 8'h3C); wr(8'h9B, 8'h11);
        rd(8'h60, 8'hA5, "R2"); rd(8'hFF, 8'h3C, "R2"); rd(8'h9B, 8'h11, "R2");

        // R9: special register slots as storage
        wr(8'h05, 8'h77); wr(8'h0A, 8'h5A); wr(8'h1E, 8'hC3); wr(8'h19, 8'h2D);
        rd(8'h05, 8'h77, "R9"); rd(8'h0A, 8'h5A, "R9");
        rd(8'h1E, 8'hC3, "R9"); rd(8'h19, 8'h2D, "R9");

        // R3: reserved holes ignore writes and read zero
        wr(8'h1B, 8'hFF); wr(8'h40, 8'hEE); wr(8'h5F, 8'hDD);
        rd(8'h1B, 8'h00, "R3"); rd(8'h40, 8'h00, "R3");
        rd(8'h5F, 8'h00, "R3"); rd(8'h1A, 8'h00, "R3");

        // R8 + R4: pointer load used by the very next access
        wr(8'h01, 8'h60);
        rd(8'h00, 8'hA5, "R8");
        chk_ptr(8'h60, 8'h00, "R8");
        wr(8'h00, 8'h42);
        rd(8'h60, 8'h42, "R4");
        rd(8'h00, 8'h42, "R4");

        // R5: second port through the second pointer
        wr(8'h03, 8'hFF);
        rd(8'h02, 8'h3C, "R5");
        wr(8'h02, 8'h81);
        rd(8'hFF, 8'h81, "R5");
        wr(8'h03, 8'h05);
        rd(8'h02, 8'h77, "R5");
        chk_ptr(8'h60, 8'h05, "R5");

        // R4: pointer aimed at the other pointer
        wr(8'h01, 8'h03);
        rd(8'h00, 8'h05, "R4");

        // R6: pointers holding virtual addresses
        wr(8'h01, 8'h02);
        rd(8'h00, 8'h00, "R6");
        wr(8'h03, 8'h00);
        rd(8'h02, 8'h00, "R6");
        wr(8'h01, 8'h00);
        rd(8'h00, 8'h00, "R6");

        // R7: blocked writes change nothing
        wr(8'h00, 8'h99);
        chk_ptr(8'h00, 8'h00, "R7");
        wr(8'h01, 8'h02);
        wr(8'h00, 8'h55);
        wr(8'h02, 8'h66);
        chk_ptr(8'h02, 8'h00, "R7");
        rd(8'h05, 8'h77, "R7");
        rd(8'h60, 8'h42, "R7");

        // R3: reserved target reached through a pointer
        wr(8'h01, 8'h30);
        rd(8'h00, 8'h00, "R3");
        wr(8'h00, 8'h12);
        rd(8'h30, 8'h00, "R3");

        // R10: same-cycle read of the byte being written
        wr(8'h70, 8'h01);
        wr_rd(8'h70, 8'h02, 8'h70, 8'h01, "R10");
        rd(8'h70, 8'h02, "R10");
        wr_rd(8'h01, 8'h70, 8'h00, 8'h00, "R10");
        rd(8'h00, 8'h02, "R10");

        @(negedge clk);
        probe = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule